// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block collects seventeen interrupt request lines and folds them into two requests toward the processor: a critical request and a non-critical request. Seven of the lines arrive from package pins and are asynchronous to the block clock. The other ten come from on-chip peripherals that already run on the block clock. Software chooses, one source at a time, whether the line is sensed by level or by edge, whether it is active high or active low, and which of the two processor requests it feeds.

Each source has a pending bit. Edge-sensed sources keep the bit set until software clears it. Level-sensed sources follow the line. An enable mask sits between the pending bits and both requests. A disabled source still shows as pending, but it cannot raise a request. Among the enabled, pending, critical sources, a priority number chosen by software picks one winner. The block then presents a ready-made vector address for that winner, so the exception handler can jump straight to it without scanning.

Configuration goes through a single-cycle register port. A write takes effect at the clock edge. Read data is a combinational function of the address.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, every register reads zero: all sources disabled, active high, level sensed, non-critical, priority 0, vector base 0 and step 0. `crit_req`, `noncrit_req`, `crit_valid` and `crit_vector` are all low.
- R2: Bit i of the invert register (address 0x02) set to 1 makes source i active low. In edge mode it also makes the falling edge the active edge.
- R3: Trigger mode is set by bit i of the edge register (address 0x03).
  - Edge mode (bit = 1): the pending bit (status register, address 0x01) is set on each inactive-to-active transition. It stays set until software writes 1 to that bit. If a new edge and a clearing write land in the same cycle, the set wins.
  - Level mode (bit = 0): the pending bit equals the active state of the line, and writes to it have no effect.
- R4: Bit i of the enable register (address 0x00) gates source i from both requests. The status register still records the source while it is disabled.
- R5: Bit i of the route register (address 0x04) set to 1 sends source i to `crit_req`, and 0 sends it to `noncrit_req`. Each request is the OR of its enabled, pending sources.
- R6: Each source has a priority field at address 0x08+i, bits [4:0]. The smaller value is more urgent. When two values are equal, the lower source index wins.
- R7: When a critical source wins, `crit_valid` is 1 and `crit_vector` = base (address 0x05) + (index << step). The step is bits [2:0] of address 0x06, and the sum wraps at 32 bits. When no critical source is enabled and pending, `crit_valid` is 0 and `crit_vector` is 0.
- R8: Source numbering is `ext_irq[k]` = source k and `int_irq[j]` = source 7+j.
  - External lines pass through two synchronizer flops, so their status changes at the third clock edge after the input changes.
  - Internal lines change status at the first clock edge.
- R9: Every register reads back its written value, masked to its implemented width: 17 bits for the bit registers, 5 bits for priorities, 3 bits for the step. Addresses with no register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq | input | 7 | Asynchronous request lines from pins (sources 0..6) |
| int_irq | input | 10 | Synchronous request lines from on-chip peripherals (sources 7..16) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| crit_req | output | 1 | Critical interrupt request |
| noncrit_req | output | 1 | Non-critical interrupt request |
| crit_vector | output | 32 | Vector address of the winning critical source |
| crit_valid | output | 1 | A critical winner is present |

## Verification
The assertions check, on every cycle, these properties:
- An edge-mode pending bit never drops unless software writes a one to it.
- A fully disabled mask silences both requests.
- A non-critical request never appears without an enabled, pending, non-critical source.
- The vector is zero and `crit_valid` tracks `crit_req` whenever no critical winner exists.

The bench scenarios cover what those rules cannot see on their own:
- which source wins under random priorities and ties;
- the exact vector arithmetic;
- the synchronizer latency of external lines against internal ones;
- the set-over-clear collision;
- the fact that level-mode status ignores writes.

// File: rtl/pic_pkg.sv
package pic_pkg;
    // Register addresses used by the configuration port
    localparam int unsigned A_ENABLE = 0;
    localparam int unsigned A_STATUS = 1;
    localparam int unsigned A_INVERT = 2;
    localparam int unsigned A_EDGE   = 3;
    localparam int unsigned A_CRIT   = 4;
    localparam int unsigned A_VBASE  = 5;
    localparam int unsigned A_VSTEP  = 6;
    localparam int unsigned A_PRIO0  = 8;
endpackage

// File: rtl/pic_src_cell.sv
// One interrupt source: optional synchronizer, polarity, edge/level capture.
module pic_src_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    input  logic edge_mode,
    input  logic clr,
    output logic status
);
    logic synced;
    logic norm;
    logic prev_q;
    logic rise;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q[0] <= raw;
                    for (int k = 1; k < SYNC_STAGES; k++) begin
                        chain_q[k] <= chain_q[k-1];
                    end
                end
            end
            assign synced = chain_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign synced = raw;
        end
    endgenerate

    assign norm = synced ^ invert;
    assign rise = norm & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            status <= 1'b0;
        end else begin
            prev_q <= norm;
            if (edge_mode) begin
                status <= rise | (status & ~clr);
            end else begin
                status <= norm;
            end
        end
    end
endmodule

// File: rtl/pic_crit_pick.sv
// Picks the most urgent critical source and forms its vector address.
module pic_crit_pick #(
    parameter int N      = 17,
    parameter int PRIO_W = 5,
    parameter int STEP_W = 3,
    parameter int VEC_W  = 32
) (
    input  logic [N-1:0]      cand,
    input  logic [PRIO_W-1:0] prio [N],
    input  logic [VEC_W-1:0]  base,
    input  logic [STEP_W-1:0] step,
    output logic [VEC_W-1:0]  vector,
    output logic              valid
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid   = 1'b0;
        best    = '0;
        win_idx = '0;
        // strict compare keeps the lowest index among equal priorities
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!valid || prio[i] < best)) begin
                valid   = 1'b1;
                best    = prio[i];
                win_idx = IDX_W'(i);
            end
        end
        vector = valid ? (base + (VEC_W'(win_idx) << step)) : '0;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N_EXT       = 7,
    parameter int N_INT       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int PRIO_W      = 5,
    parameter int STEP_W      = 3,
    parameter int VEC_W       = 32,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_INT-1:0]  int_irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              crit_req,
    output logic              noncrit_req,
    output logic [VEC_W-1:0]  crit_vector,
    output logic              crit_valid
);
    localparam int N = N_EXT + N_INT;

    logic [N-1:0]      enable_q, invert_q, edge_q, crit_q;
    logic [N-1:0]      status_q;
    logic [N-1:0]      raw_in;
    logic [N-1:0]      clr_mask;
    logic [N-1:0]      live;
    logic [PRIO_W-1:0] prio_q [N];
    logic [VEC_W-1:0]  vbase_q;
    logic [STEP_W-1:0] vstep_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
        return a == ADDR_W'(r);
    endfunction

    assign raw_in   = {int_irq, ext_irq};
    assign clr_mask = (reg_wr && hit(reg_addr, A_STATUS)) ? reg_wdata[N-1:0] : '0;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            invert_q <= '0;
            edge_q   <= '0;
            crit_q   <= '0;
            vbase_q  <= '0;
            vstep_q  <= '0;
            for (int i = 0; i < N; i++) prio_q[i] <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, A_ENABLE)) enable_q <= reg_wdata[N-1:0];
            if (hit(reg_addr, A_INVERT)) invert_q <= reg_wdata[N-1:0];
            if (hit(reg_addr, A_EDGE))   edge_q   <= reg_wdata[N-1:0];
            if (hit(reg_addr, A_CRIT))   crit_q   <= reg_wdata[N-1:0];
            if (hit(reg_addr, A_VBASE))  vbase_q  <= reg_wdata[VEC_W-1:0];
            if (hit(reg_addr, A_VSTEP))  vstep_q  <= reg_wdata[STEP_W-1:0];
            for (int i = 0; i < N; i++) begin
                if (hit(reg_addr, A_PRIO0 + i)) prio_q[i] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    // per-source capture cells; only pin lines get the synchronizer
    generate
        for (genvar g = 0; g < N; g++) begin : g_src
            pic_src_cell #(
                .SYNC_STAGES((g < N_EXT) ? SYNC_STAGES : 0)
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw       (raw_in[g]),
                .invert    (invert_q[g]),
                .edge_mode (edge_q[g]),
                .clr       (clr_mask[g]),
                .status    (status_q[g])
            );
        end
    endgenerate

    assign live        = status_q & enable_q;
    assign crit_req    = |(live & crit_q);
    assign noncrit_req = |(live & ~crit_q);

    pic_crit_pick #(
        .N      (N),
        .PRIO_W (PRIO_W),
        .STEP_W (STEP_W),
        .VEC_W  (VEC_W)
    ) u_pick (
        .cand   (live & crit_q),
        .prio   (prio_q),
        .base   (vbase_q),
        .step   (vstep_q),
        .vector (crit_vector),
        .valid  (crit_valid)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, A_ENABLE)) reg_rdata = DATA_W'(enable_q);
        if (hit(reg_addr, A_STATUS)) reg_rdata = DATA_W'(status_q);
        if (hit(reg_addr, A_INVERT)) reg_rdata = DATA_W'(invert_q);
        if (hit(reg_addr, A_EDGE))   reg_rdata = DATA_W'(edge_q);
        if (hit(reg_addr, A_CRIT))   reg_rdata = DATA_W'(crit_q);
        if (hit(reg_addr, A_VBASE))  reg_rdata = DATA_W'(vbase_q);
        if (hit(reg_addr, A_VSTEP))  reg_rdata = DATA_W'(vstep_q);
        for (int i = 0; i < N; i++) begin
            if (hit(reg_addr, A_PRIO0 + i)) reg_rdata = DATA_W'(prio_q[i]);
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
#(
    parameter int N      = 17,
    parameter int VEC_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      status,
    input logic [N-1:0]      enable,
    input logic [N-1:0]      edgem,
    input logic [N-1:0]      crit,
    input logic              crit_req,
    input logic              noncrit_req,
    input logic              crit_valid,
    input logic [VEC_W-1:0]  crit_vector,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [N-1:0]      clr_data
);
    logic [N-1:0] keep;
    logic         edge_wr;

    always_comb begin
        keep    = edgem & status &
                  ~((reg_wr && reg_addr == ADDR_W'(A_STATUS)) ? clr_data : '0);
        edge_wr = reg_wr && reg_addr == ADDR_W'(A_EDGE);
    end

    // R3: an edge-mode pending bit survives unless a write of 1 clears it
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_wr |=> ((status & $past(keep)) == $past(keep)));

    // R4: with every source masked no request reaches the processor
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> (!crit_req && !noncrit_req));

    // R5: non-critical request only from an enabled pending non-critical source
    p_noncrit_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        noncrit_req |-> ((status & enable & ~crit) != '0));

    // R7: a critical winner exists exactly when the critical request is up
    p_valid_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid == crit_req);

    // R7: no winner means a zero vector
    p_vec_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !crit_valid |-> (crit_vector == '0));
endmodule

bind pic_ctrl pic_ctrl_chk #(
    .N      (N_EXT + N_INT),
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status_q),
    .enable      (enable_q),
    .edgem       (edge_q),
    .crit        (crit_q),
    .crit_req    (crit_req),
    .noncrit_req (noncrit_req),
    .crit_valid  (crit_valid),
    .crit_vector (crit_vector),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .clr_data    (reg_wdata[N_EXT+N_INT-1:0])
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
    localparam int N = 17;
    localparam logic [N-1:0] ALL = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ext_irq = '0;
    logic [9:0]  int_irq = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        crit_req, noncrit_req, crit_valid;
    logic [31:0] crit_vector;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench copy of the configuration
    logic [N-1:0] m_en, m_inv, m_edge, m_crit;
    int           m_prio [N];
    logic [31:0]  m_base;
    int           m_step;

    pic_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .int_irq(int_irq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .crit_req(crit_req), .noncrit_req(noncrit_req),
        .crit_vector(crit_vector), .crit_valid(crit_valid)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [N-1:0] v);
        ext_irq = v[6:0];
        int_irq = v[16:7];
    endtask

    function automatic logic [31:0] exp_vec(input logic [N-1:0] st);
        int w = -1;
        int b = 0;
        for (int i = 0; i < N; i++) begin
            if (st[i] && m_en[i] && m_crit[i] && (w < 0 || m_prio[i] < b)) begin
                w = i; b = m_prio[i];
            end
        end
        if (w < 0) return 32'd0;
        return m_base + (32'(w) << m_step);
    endfunction

    task automatic check_all(input string tag, input logic [N-1:0] st);
        logic [31:0] d;
        logic [31:0] ev;
        rd(1, d);
        chk({tag, " R2/R3 status"}, d, 32'(st));
        chk({tag, " R5 crit_req"}, 32'(crit_req), 32'(|(st & m_en & m_crit)));
        chk({tag, " R4/R5 noncrit_req"}, 32'(noncrit_req), 32'(|(st & m_en & ~m_crit)));
        ev = exp_vec(st);
        chk({tag, " R6/R7 vector"}, crit_vector, ev);
        chk({tag, " R7 valid"}, 32'(crit_valid), 32'(|(st & m_en & m_crit)));
    endtask

    task automatic load_cfg();
        wr(0, 32'(m_en));
        wr(2, 32'(m_inv));
        wr(3, 32'(m_edge));
        wr(4, 32'(m_crit));
        wr(5, m_base);
        wr(6, 32'(m_step));
        for (int i = 0; i < N; i++) wr(8 + i, 32'(m_prio[i]));
    endtask

    initial begin
        logic [31:0] d;
        logic [N-1:0] act;
        void'($urandom(32'd1234));
        m_en = '0; m_inv = '0; m_edge = '0; m_crit = '0;
        m_base = '0; m_step = 0;
        for (int i = 0; i < N; i++) m_prio[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every address and the outputs
        for (int a = 0; a < 32; a++) begin
            rd(a, d);
            chk("R1 reset register", d, 32'd0);
        end
        chk("R1 reset outputs", {28'd0, crit_req, noncrit_req, crit_valid, |crit_vector}, 32'd0);

        // R9: masked readback and unused address
        wr(8, 32'hFFFF_FFFF);
        rd(8, d);  chk("R9 priority width", d, 32'h1F);
        wr(6, 32'hFFFF_FFFF);
        rd(6, d);  chk("R9 step width", d, 32'h7);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d);  chk("R9 enable width", d, 32'h1FFFF);
        wr(7, 32'hFFFF_FFFF);
        rd(7, d);  chk("R9 unused address", d, 32'd0);
        wr(8, 0); wr(6, 0); wr(0, 0);

        // R8: external latency of three edges, internal of one
        @(negedge clk);
        ext_irq[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1, d); chk("R8 external not yet visible", d & 32'h1, 32'h0);
        @(negedge clk);
        rd(1, d); chk("R8 external after three edges", d & 32'h1, 32'h1);
        int_irq[0] = 1'b1;
        @(negedge clk);
        rd(1, d); chk("R8 internal after one edge", d & 32'h80, 32'h80);

        // R4: disabled sources still recorded, no request
        chk("R4 masked no request", 32'({crit_req, noncrit_req}), 32'd0);

        // R3: level status ignores writes of one
        wr(1, 32'h80);
        rd(1, d); chk("R3 level ignores clear", d & 32'h80, 32'h80);
        int_irq[0] = 1'b0; ext_irq[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, d); chk("R3 level follows input", d, 32'h0);

        // R3: set wins over a clear in the same cycle (edge mode on source 7)
        wr(3, 32'h80);
        @(negedge clk);
        int_irq[0] = 1'b1;
        reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h80;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(1, d); chk("R3 set wins over clear", d & 32'h80, 32'h80);
        int_irq[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd(1, d); chk("R3 edge status sticky", d & 32'h80, 32'h80);
        wr(1, 32'h80);
        rd(1, d); chk("R3 write one clears", d & 32'h80, 32'h0);
        wr(3, 0);

        // R2: active-low internal source 8
        wr(2, 32'h100);
        @(negedge clk);
        rd(1, d); chk("R2 inverted idle line is active", d & 32'h100, 32'h100);
        int_irq[1] = 1'b1;
        @(negedge clk);
        rd(1, d); chk("R2 inverted high line inactive", d & 32'h100, 32'h0);
        int_irq[1] = 1'b0;
        wr(2, 0);

        // R6/R7: tie at equal priority, then a more urgent higher index
        m_en = (17'(1) << 7) | (17'(1) << 12);
        m_crit = m_en; m_inv = '0; m_edge = '0;
        for (int i = 0; i < N; i++) m_prio[i] = 3;
        m_base = 32'h1000; m_step = 4;
        load_cfg();
        int_irq[0] = 1'b1; int_irq[5] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 tie lower index", crit_vector, 32'h1070);
        chk("R5 critical request", 32'(crit_req), 32'd1);
        chk("R5 no non-critical", 32'(noncrit_req), 32'd0);
        wr(8 + 12, 1); m_prio[12] = 1;
        chk("R6 smaller value wins", crit_vector, 32'h10C0);
        int_irq = '0;
        repeat (2) @(negedge clk);
        chk("R7 zero when idle", crit_vector, 32'd0);

        // random trials
        for (int t = 0; t < 40; t++) begin
            m_en   = N'($urandom);
            m_inv  = N'($urandom);
            m_edge = N'($urandom);
            m_crit = N'($urandom);
            for (int i = 0; i < N; i++) m_prio[i] = int'($urandom % 32);
            m_base = $urandom;
            m_step = int'($urandom % 8);
            if (t == 0) m_en = '0;
            load_cfg();
            drive(m_inv);
            repeat (5) @(negedge clk);
            wr(1, 32'(ALL));
            rd(1, d); chk("R3 random clear", d, 32'd0);
            act = N'($urandom);
            drive(act ^ m_inv);
            repeat (5) @(negedge clk);
            check_all("random active", act);
            drive(m_inv);
            repeat (5) @(negedge clk);
            check_all("random released", act & m_edge);
        end

        summary();
        $finish;
    end
endmodule